// File: doc/BRIEF.md
# Ternary Carry-Lookahead Adder

This block adds two unsigned ternary operands whose digits take the values 0, 1 and 2, together with a single binary carry-in, and returns a ternary sum plus a binary carry-out. Every digit travels on a pair of wires. The carries between digit positions are always single binary signals: adding two digits and a carry never gives more than 5, so the carry out of any position is at most 1.

Each position derives two binary flags from its digit pair. The generate flag is set when the pair sums to 3 or more. The propagate flag is set when the pair sums to exactly 2. A single flat lookahead block turns all generate and propagate flags, plus the carry-in, into every position's incoming carry at once, with no ripple chain. A 1-trit full adder per position then forms the sum digit from the two digits and its incoming carry. The digit count is a parameter (default 5, range 0..242 per operand). The sum, carry-out and a code-error flag are captured in one output register stage.

Top module: `tern_cla_adder`

## Requirements
- R1: For legal operands A, B and carry-in c applied before a rising clock edge, after that edge value(sum_out) + 3^NTRIT * carry_out equals A + B + c.
- R2: Trit i of every operand and of sum_out sits at bits [2i+1:2i]. The code is 00 = 0, 01 = 1, 10 = 2, and 11 is illegal. sum_out never carries the code 11.
- R3: A position whose digit pair sums to 3 or more (pairs 1/2, 2/1, 2/2) carries into the next position whatever carry it receives.
- R4: A position whose digit pair sums to exactly 2 (pairs 0/2, 1/1, 2/0) passes its incoming carry on unchanged. With every position propagating, carry_out equals carry_in, and the sum digits are all 2 (carry_in = 0) or all 0 (carry_in = 1).
- R5: Sum digit i equals (Ai + Bi + Ci) mod 3. The lookahead carry into position i+1 matches the carry produced by position i's full adder.
- R6: While rst_n is low, sum_out, carry_out and code_err are all zero after each clock edge.
- R7: code_err is 1 after an edge at which any trit of op_a or op_b held the code 11, and 0 after an edge at which all trits were legal.
- R8: A position whose digit pair sums to 1 or less never carries out, even when its incoming carry is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 2*NTRIT | First operand, two wires per trit |
| op_b | input | 2*NTRIT | Second operand, two wires per trit |
| carry_in | input | 1 | Binary carry into position 0 |
| sum_out | output | 2*NTRIT | Registered ternary sum |
| carry_out | output | 1 | Registered binary carry out of the top position |
| code_err | output | 1 | Registered flag: an input trit held code 11 |

## Verification
The bench builds the block with the default NTRIT = 5. At that size the whole legal input space (243 × 243 operand pairs × 2 carry-in values) fits in one exhaustive sweep, so every digit pair meets every incoming carry in every position. The sweep includes the full propagate chain from carry_in to carry_out and the top-position overflow. Directed cases add the reset state, the all-propagate and all-kill patterns, and illegal codes in single trits of each operand.

// File: rtl/tern_pkg.sv
package tern_pkg;
    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_ONE  = 2'b01;
    localparam trit_t TRIT_TWO  = 2'b10;
    localparam trit_t TRIT_BAD  = 2'b11;

    // Digit value of a code; the illegal code reads as zero.
    function automatic logic [1:0] trit_value(input trit_t code);
        return (code == TRIT_BAD) ? 2'd0 : code;
    endfunction
endpackage

// File: rtl/tern_gp.sv
module tern_gp
    import tern_pkg::*;
(
    input  trit_t digit_a,
    input  trit_t digit_b,
    output logic  gen,
    output logic  prop,
    output logic  bad
);
    logic [2:0] pair_sum;

    always_comb begin
        pair_sum = {1'b0, trit_value(digit_a)} + {1'b0, trit_value(digit_b)};
        gen      = (pair_sum >= 3'd3);
        prop     = (pair_sum == 3'd2);
        bad      = (digit_a == TRIT_BAD) || (digit_b == TRIT_BAD);
    end
endmodule

// File: rtl/tern_lookahead.sv
module tern_lookahead #(
    parameter int NTRIT = 5
) (
    input  logic [NTRIT-1:0] gen,
    input  logic [NTRIT-1:0] prop,
    input  logic             cin,
    output logic [NTRIT:0]   carry
);
    // Flat sum-of-products per carry: no carry feeds another.
    always_comb begin
        logic term;
        logic acc;
        carry[0] = cin;
        for (int i = 0; i < NTRIT; i++) begin
            term = cin;
            for (int k = 0; k <= i; k++) term = term & prop[k];
            acc = term;
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prop[k];
                acc = acc | term;
            end
            carry[i+1] = acc;
        end
    end
endmodule

// File: rtl/tern_full_adder.sv
module tern_full_adder
    import tern_pkg::*;
(
    input  trit_t digit_a,
    input  trit_t digit_b,
    input  logic  cin,
    output trit_t digit_s,
    output logic  cout
);
    logic [2:0] total;

    always_comb begin
        total = {1'b0, trit_value(digit_a)} + {1'b0, trit_value(digit_b)} + {2'b00, cin};
        cout  = (total >= 3'd3);
        digit_s = cout ? trit_t'(total - 3'd3) : trit_t'(total);
    end
endmodule

// File: rtl/tern_cla_adder.sv
module tern_cla_adder
    import tern_pkg::*;
#(
    parameter int NTRIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NTRIT-1:0] op_a,
    input  logic [2*NTRIT-1:0] op_b,
    input  logic               carry_in,
    output logic [2*NTRIT-1:0] sum_out,
    output logic               carry_out,
    output logic               code_err
);
    localparam int W = 2 * NTRIT;

    logic [NTRIT-1:0] gen;
    logic [NTRIT-1:0] prop;
    logic [NTRIT-1:0] bad;
    logic [NTRIT-1:0] fa_cy;
    logic [NTRIT:0]   carry;
    logic [W-1:0]     sum_d;

    for (genvar i = 0; i < NTRIT; i++) begin : g_pos
        tern_gp u_gp (
            .digit_a (op_a[2*i +: 2]),
            .digit_b (op_b[2*i +: 2]),
            .gen     (gen[i]),
            .prop    (prop[i]),
            .bad     (bad[i])
        );

        tern_full_adder u_fa (
            .digit_a (op_a[2*i +: 2]),
            .digit_b (op_b[2*i +: 2]),
            .cin     (carry[i]),
            .digit_s (sum_d[2*i +: 2]),
            .cout    (fa_cy[i])
        );

        // R3: generate forces a carry out of this position
        assert_gen_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
            gen[i] |-> carry[i+1]);
        // R4: propagate hands the incoming carry on unchanged
        assert_prop_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            prop[i] |-> (carry[i+1] == carry[i]));
        // R8: neither generate nor propagate kills the carry
        assert_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!gen[i] && !prop[i]) |-> !carry[i+1]);
    end

    tern_lookahead #(.NTRIT(NTRIT)) u_cla (
        .gen   (gen),
        .prop  (prop),
        .cin   (carry_in),
        .carry (carry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out   <= '0;
            carry_out <= 1'b0;
            code_err  <= 1'b0;
        end else begin
            sum_out   <= sum_d;
            carry_out <= carry[NTRIT];
            code_err  <= |bad;
        end
    end

    // R5: lookahead carries agree with the per-digit full adders
    assert_fa_carry_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fa_cy == carry[NTRIT:1]);
    // R7: an illegal input code is flagged on the next cycle
    assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|bad) |=> code_err);
    // R2: the registered sum never holds the illegal code
    for (genvar i = 0; i < NTRIT; i++) begin : g_chk
        assert_sum_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sum_out[2*i +: 2] != TRIT_BAD);
    end
endmodule

// File: tb/tb_tern_cla_adder.sv
`timescale 1ns/1ps
module tb_tern_cla_adder;
    localparam int NTRIT = 5;
    localparam int W = 2 * NTRIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic carry_out;
    logic code_err;

    int checks = 0;
    int fails = 0;
    int modulus;

    always #2 clk = ~clk;

    tern_cla_adder #(.NTRIT(NTRIT)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .sum_out(sum_out), .carry_out(carry_out),
        .code_err(code_err)
    );

    function automatic logic [W-1:0] to_trits(input int v);
        logic [W-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < NTRIT; i++) begin
            r[2*i +: 2] = 2'(x % 3);
            x = x / 3;
        end
        return r;
    endfunction

    function automatic int from_trits(input logic [W-1:0] t);
        int v;
        v = 0;
        for (int i = NTRIT - 1; i >= 0; i--) v = v * 3 + int'(t[2*i +: 2]);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        op_a = a;
        op_b = b;
        carry_in = c;
        @(posedge clk);
        #1;
    endtask

    task automatic sum_legal();
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < NTRIT; i++) if (sum_out[2*i +: 2] == 2'b11) ok = 1'b0;
        check(ok, "R2 sum code legal", int'(sum_out), 0);
    endtask

    initial begin
        modulus = 1;
        for (int i = 0; i < NTRIT; i++) modulus = modulus * 3;

        // R6: reset holds outputs at zero despite busy inputs
        apply(to_trits(200), to_trits(100), 1'b1);
        check(sum_out == '0, "R6 reset sum", int'(sum_out), 0);
        check(carry_out == 1'b0, "R6 reset carry", int'(carry_out), 0);
        op_a[1:0] = 2'b11;
        @(posedge clk); #1;
        check(code_err == 1'b0, "R6 reset err", int'(code_err), 0);
        rst_n = 1'b1;

        // R4: full propagate chain, each pair sums to 2
        apply(to_trits(modulus - 1), '0, 1'b1);
        check(sum_out == '0 && carry_out == 1'b1, "R4 chain cin=1",
              from_trits(sum_out) + modulus * int'(carry_out), modulus);
        apply(to_trits(121), to_trits(121), 1'b0);
        check(from_trits(sum_out) == modulus - 1 && carry_out == 1'b0, "R4 chain cin=0",
              from_trits(sum_out) + modulus * int'(carry_out), modulus - 1);

        // R8: all-kill pattern, carry-in only reaches digit 0
        apply(to_trits(121), '0, 1'b1);
        check(from_trits(sum_out) == 122 && carry_out == 1'b0, "R8 kill",
              from_trits(sum_out) + modulus * int'(carry_out), 122);

        // R3: generate at the top digit only (2+1 in digit 4)
        apply(to_trits(162), to_trits(81), 1'b0);
        check(carry_out == 1'b1 && sum_out == '0, "R3 top generate",
              from_trits(sum_out) + modulus * int'(carry_out), 243);

        // R5: mixed digits, explicit per-digit sum
        apply(to_trits(1 + 2*3 + 2*9), to_trits(1 + 1*3 + 2*9), 1'b1);
        check(from_trits(sum_out) == (0 + 1*3 + 2*9 + 1*27) && carry_out == 1'b0,
              "R5 digit sums", from_trits(sum_out), 48);

        // R7: illegal code in each operand, then clear
        begin
            logic [W-1:0] t;
            t = to_trits(50);
            t[5:4] = 2'b11;
            apply(t, to_trits(3), 1'b0);
            check(code_err == 1'b1, "R7 bad op_a", int'(code_err), 1);
            t = to_trits(7);
            t[W-1 -: 2] = 2'b11;
            apply(to_trits(3), t, 1'b1);
            check(code_err == 1'b1, "R7 bad op_b", int'(code_err), 1);
            apply(to_trits(3), to_trits(4), 1'b0);
            check(code_err == 1'b0, "R7 flag clears", int'(code_err), 0);
        end

        // R1: exhaustive sweep of legal operands
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < modulus; a++) begin
                for (int b = 0; b < modulus; b++) begin
                    apply(to_trits(a), to_trits(b), 1'(c));
                    check(from_trits(sum_out) + modulus * int'(carry_out) == a + b + c
                          && code_err == 1'b0, "R1 sum value",
                          from_trits(sum_out) + modulus * int'(carry_out), a + b + c);
                    sum_legal();
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule